// File: doc/BRIEF.md
# Serial Register-Access Slave with Selectable Bit Order

This block lets an external host reach a bank of 8-bit registers, addressed by 14 bits, over a four-wire serial link. The host frames each transaction with an active-low chip select. It sends a 16-bit control word and then one or more data bytes. Clock polarity, clock phase and bit order are fixed by three static mode inputs, which must not change while chip select is asserted.

The serial pins are brought into the system clock domain through two-flop synchronisers, and clock edges are found by oversampling. The system clock must therefore run well above the serial clock: each half period of the serial clock has to span at least six system cycles. On the register side the block offers plain strobes: an address, write data with a one-cycle write enable, and a one-cycle read enable. While the read enable is high, the register bank must present the addressed byte on the read-data input in that same cycle. The serial output comes with an enable for an external tri-state pad.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, and while chip select is high, `misoOe`, `miso`, `regWrEn` and `regRdEn` are all 0.
- R2: The control word is 16 bits. The first bit is the direction (1 = read, 0 = write), the next 14 bits are the address and the last bit is the burst flag.
- R3: With `msbFirst` = 0, the address and data bits travel least significant bit first. With `msbFirst` = 1 they travel most significant bit first. The direction bit stays first and the burst flag stays last in both cases.
- R4: MOSI is sampled on the rising SCLK edge when `cpol` equals `cpha`, and on the falling edge otherwise. MISO changes only on the opposite edge, so the host can take it on its sampling edge.
- R5: In a write, the 8th sampled data bit produces a single one-cycle `regWrEn` pulse. During that pulse `regAddr` holds the target address and `regWrData` holds the assembled byte.
- R6: In a read, completing the control word produces a single one-cycle `regRdEn` pulse. The byte on `regRdData` in that cycle is shifted out on MISO, and its first bit is in place before the first data sampling edge.
- R7: With the burst flag set, the address rises by one after every data byte and wraps from 0x3FFF to 0x0000. Each following byte uses the new address, and a read fetches the next byte at that address.
- R8: With the burst flag clear, exactly one byte is transferred. Any further SCLK edges are ignored until chip select rises.
- R9: Raising chip select in the middle of a byte discards the partial byte and issues no write. The next transaction starts again from the first control-word bit.
- R10: `misoOe` is high only while the synchronised chip select is low. `miso` is 0 whenever `misoOe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | SCLK idle level (static) |
| cpha | input | 1 | 0: sample on the leading edge, 1: sample on the trailing edge (static) |
| msbFirst | input | 1 | Bit order of the address and data fields (static) |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| csN | input | 1 | Active-low chip select |
| miso | output | 1 | Serial data to the host |
| misoOe | output | 1 | Output enable for the MISO pad |
| regAddr | output | 14 | Register address |
| regWrData | output | 8 | Register write data |
| regWrEn | output | 1 | One-cycle write strobe |
| regRdEn | output | 1 | One-cycle read strobe |
| regRdData | input | 8 | Register read data, valid while regRdEn is high |

## Verification
A table of transactions covers all four clock modes, each paired with both bit orders, for single and burst writes and reads. Addresses and data bytes are asymmetric, so a reversed field or a wrong sampling edge gives a different address, write byte or read byte. Burst entries start at 0x3FFE and 0x3FFF, which tells a correct increment and wrap apart from a stuck or unwrapped address. Directed cases clock extra bytes after a single transfer, abort a write in mid-byte and then repeat it cleanly, and watch the output enable around chip select.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } phase_e;

  // strobes from control to datapath, valid for one cycle each
  typedef struct packed {
    logic clear;     // chip select inactive: drop partial state
    logic addrBit;   // shift sampled bit into the address
    logic dataBit;   // shift sampled bit into the receive byte
    logic fetch;     // issue a register read
    logic commit;    // issue a register write
    logic advance;   // step the burst address
    logic txShift;   // present next read bit on MISO
  } strobe_t;

endpackage

// File: rtl/spi_reg_sync.sv
module spi_reg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : gSync
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= {STAGES{RST_VAL[g]}};
        else       pipe <= {pipe[STAGES-2:0], din[g]};
      end
      assign dout[g] = pipe[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cpol,
  input  logic    cpha,
  input  logic    sclkS,
  input  logic    mosiS,
  input  logic    csNS,
  output logic    csActive,
  output strobe_t strb
);

  localparam int CMD_BITS  = ADDR_W + 2;
  localparam int CNT_MAX   = (CMD_BITS > DATA_W) ? CMD_BITS : DATA_W;
  localparam int CNT_W     = $clog2(CNT_MAX);
  localparam int CMD_LAST  = CMD_BITS - 1;
  localparam int DATA_LAST = DATA_W - 1;

  logic sclkPrev;
  logic rise, fall, sampleOnRise, sampleEdge, shiftEdge;
  phase_e phase;
  logic [CNT_W-1:0] bitCnt;
  logic rwFlag, burstFlag, advPend, fetchPend;
  logic lastCmd, byteDone;

  assign csActive     = ~csNS;
  assign rise         = sclkS & ~sclkPrev;
  assign fall         = ~sclkS & sclkPrev;
  assign sampleOnRise = (cpol == cpha);
  assign sampleEdge   = csActive & (sampleOnRise ? rise : fall);
  assign shiftEdge    = csActive & (sampleOnRise ? fall : rise);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkPrev <= 1'b0;
    else       sclkPrev <= sclkS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_CMD;
      bitCnt    <= '0;
      rwFlag    <= 1'b0;
      burstFlag <= 1'b0;
      advPend   <= 1'b0;
      fetchPend <= 1'b0;
    end else if (!csActive) begin
      phase     <= PH_CMD;
      bitCnt    <= '0;
      rwFlag    <= 1'b0;
      burstFlag <= 1'b0;
      advPend   <= 1'b0;
      fetchPend <= 1'b0;
    end else begin
      advPend   <= 1'b0;
      fetchPend <= advPend & rwFlag;
      if (sampleEdge) begin
        case (phase)
          PH_CMD: begin
            if (bitCnt == '0) rwFlag <= mosiS;
            if (bitCnt == CNT_W'(CMD_LAST)) begin
              burstFlag <= mosiS;
              phase     <= PH_DATA;
              bitCnt    <= '0;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          PH_DATA: begin
            if (bitCnt == CNT_W'(DATA_LAST)) begin
              bitCnt <= '0;
              if (burstFlag) advPend <= 1'b1;
              else           phase   <= PH_DONE;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign lastCmd  = sampleEdge && (phase == PH_CMD) && (bitCnt == CNT_W'(CMD_LAST));
  assign byteDone = sampleEdge && (phase == PH_DATA) && (bitCnt == CNT_W'(DATA_LAST));

  always_comb begin
    strb         = '0;
    strb.clear   = ~csActive;
    strb.addrBit = sampleEdge && (phase == PH_CMD) && (bitCnt != '0)
                   && (bitCnt != CNT_W'(CMD_LAST));
    strb.dataBit = sampleEdge && (phase == PH_DATA);
    strb.fetch   = csActive && ((lastCmd && rwFlag) || fetchPend);
    strb.commit  = byteDone && !rwFlag;
    strb.advance = csActive && advPend;
    strb.txShift = shiftEdge && (phase == PH_DATA) && rwFlag;
  end

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleEdge && shiftEdge)); // R4
  AST_DATA_CNT: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA) |-> (bitCnt < CNT_W'(DATA_W))); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DONE) |-> !burstFlag); // R8

endmodule

// File: rtl/spi_reg_dpath.sv
module spi_reg_dpath
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              mosiS,
  input  logic              msbFirst,
  input  logic [DATA_W-1:0] regRdData,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdEn,
  output logic              misoBit
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] rxData, txData;
  logic wrEnReg, rdEnReg, misoReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      rxData  <= '0;
      txData  <= '0;
      misoReg <= 1'b0;
      wrEnReg <= 1'b0;
      rdEnReg <= 1'b0;
    end else begin
      wrEnReg <= strb.commit;
      rdEnReg <= strb.fetch;
      if (strb.clear) begin
        rxData  <= '0;
        txData  <= '0;
        misoReg <= 1'b0;
      end else begin
        if (strb.addrBit)
          addrReg <= msbFirst ? {addrReg[ADDR_W-2:0], mosiS}
                              : {mosiS, addrReg[ADDR_W-1:1]};
        else if (strb.advance)
          addrReg <= addrReg + 1'b1;
        if (strb.dataBit)
          rxData <= msbFirst ? {rxData[DATA_W-2:0], mosiS}
                             : {mosiS, rxData[DATA_W-1:1]};
        if (rdEnReg) begin
          txData <= regRdData;
        end else if (strb.txShift) begin
          misoReg <= msbFirst ? txData[DATA_W-1] : txData[0];
          txData  <= msbFirst ? {txData[DATA_W-2:0], 1'b0}
                              : {1'b0, txData[DATA_W-1:1]};
        end
      end
    end
  end

  assign regAddr   = addrReg;
  assign regWrData = rxData;
  assign regWrEn   = wrEnReg;
  assign regRdEn   = rdEnReg;
  assign misoBit   = misoReg;

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wrEnReg |=> !wrEnReg); // R5
  AST_WR_RD_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEnReg && rdEnReg)); // R5
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdEnReg |=> !rdEnReg); // R6
  AST_WR_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    wrEnReg |-> $stable(addrReg)); // R7
  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (!wrEnReg && !rdEnReg)); // R9

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              msbFirst,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              csN,
  output logic              miso,
  output logic              misoOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrEn,
  output logic              regRdEn,
  input  logic [DATA_W-1:0] regRdData
);

  logic [2:0] pinSync;
  logic csActive, misoBit;
  strobe_t strb;

  spi_reg_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) sync_i (
    .clk (clk),
    .rstN(rstN),
    .din ({csN, mosi, sclk}),
    .dout(pinSync)
  );

  spi_reg_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .cpol    (cpol),
    .cpha    (cpha),
    .sclkS   (pinSync[0]),
    .mosiS   (pinSync[1]),
    .csNS    (pinSync[2]),
    .csActive(csActive),
    .strb    (strb)
  );

  spi_reg_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .mosiS    (pinSync[1]),
    .msbFirst (msbFirst),
    .regRdData(regRdData),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .misoBit  (misoBit)
  );

  assign misoOe = csActive;
  assign miso   = csActive & misoBit;

endmodule

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb_top;

  localparam int H = 8;  // system clocks per SCLK half period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpolR = 1'b0, cphaR = 1'b0, swapR = 1'b0;
  logic sclk = 1'b0, mosi = 1'b0, csN = 1'b1;
  logic miso, misoOe, regWrEn, regRdEn;
  logic [13:0] regAddr;
  logic [7:0] regWrData, regRdData;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;

  logic [13:0] wrAddr [0:7];
  logic [7:0]  wrData [0:7];
  int wrCount = 0;
  int rdCount = 0;
  logic [7:0] rxBytes [0:3];

  always #4 clk = ~clk;

  function automatic logic [7:0] rdPattern(input logic [13:0] a);
    return a[7:0] ^ {a[13:8], 2'b01} ^ 8'h3C;
  endfunction

  assign regRdData = rdPattern(regAddr);

  spi_reg_slave dut_i (
    .clk(clk), .rstN(rstN), .cpol(cpolR), .cpha(cphaR), .msbFirst(swapR),
    .sclk(sclk), .mosi(mosi), .csN(csN), .miso(miso), .misoOe(misoOe),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regRdData(regRdData)
  );

  always @(negedge clk) begin
    if (regWrEn) begin
      if (wrCount < 8) begin
        wrAddr[wrCount] = regAddr;
        wrData[wrCount] = regWrData;
      end
      wrCount++;
    end
    if (regRdEn) rdCount++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
      $finish;
    end
  endtask

  task automatic spiXfer(input logic pol, input logic pha, input logic swp,
                         input logic rw, input logic bst, input logic [13:0] addr,
                         input logic [7:0] wd, input int nBytes, input int abortAt);
    int total, k, j, idx;
    logic b, capBit;
    logic [7:0] byteV;
    cpolR = pol; cphaR = pha; swapR = swp; sclk = pol;
    repeat (H) @(negedge clk);
    csN = 1'b0;
    repeat (H) @(negedge clk);
    total = 16 + 8 * nBytes;
    for (int i = 0; i < total; i++) begin
      if (abortAt >= 0 && i == abortAt) break;
      k = (i >= 16) ? (i - 16) / 8 : 0;
      j = (i >= 16) ? (i - 16) % 8 : 0;
      idx = swp ? 7 - j : j;
      byteV = wd + 8'(k);
      if (i == 0)       b = rw;
      else if (i < 15)  b = swp ? addr[14 - i] : addr[i - 1];
      else if (i == 15) b = bst;
      else              b = byteV[idx];
      if (!pha) begin
        mosi = b;
        repeat (H) @(negedge clk);
        capBit = miso; sclk = ~pol;
        repeat (H) @(negedge clk);
        sclk = pol;
      end else begin
        sclk = ~pol; mosi = b;
        repeat (H) @(negedge clk);
        capBit = miso; sclk = pol;
        repeat (H) @(negedge clk);
      end
      if (i >= 16 && k < 4) rxBytes[k][idx] = capBit;
    end
    repeat (H) @(negedge clk);
    csN = 1'b1; mosi = 1'b0;
    repeat (2 * H) @(negedge clk);
  endtask

  // {cpol, cpha, msbFirst, read, burst, addr[13:0], wdata[7:0]}
  localparam logic [26:0] VEC [0:7] = '{
    {3'b000, 1'b0, 1'b0, 14'h0123, 8'h5A},
    {3'b011, 1'b0, 1'b0, 14'h2A55, 8'hC3},
    {3'b100, 1'b1, 1'b0, 14'h1F0E, 8'h00},
    {3'b111, 1'b1, 1'b0, 14'h0ABC, 8'h00},
    {3'b001, 1'b0, 1'b1, 14'h3FFE, 8'h10},
    {3'b110, 1'b1, 1'b1, 14'h3FFF, 8'h00},
    {3'b101, 1'b0, 1'b1, 14'h0100, 8'hF0},
    {3'b010, 1'b1, 1'b1, 14'h2001, 8'h00}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nErr++;
      $display("FAIL watchdog all-requirements actual=timeout expected=done");
      finishRun();
    end
  end

  initial begin
    logic [26:0] e;
    logic [13:0] a;
    logic [7:0] w;
    int nb;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 misoOe", 32'(misoOe), 32'd0);
    chk("R1 miso", 32'(miso), 32'd0);
    chk("R1 regWrEn", 32'(regWrEn), 32'd0);
    chk("R1 regRdEn", 32'(regRdEn), 32'd0);

    // table of transactions over all modes and bit orders
    for (int v = 0; v < 8; v++) begin
      e = VEC[v];
      a = e[21:8]; w = e[7:0];
      nb = e[22] ? 3 : 1;
      wrCount = 0; rdCount = 0;
      spiXfer(e[26], e[25], e[24], e[23], e[22], a, w, nb, -1);
      if (!e[23]) begin
        chk("R5 R8 write count", 32'(wrCount), 32'(nb));
        for (int k = 0; k < nb; k++) begin
          chk("R2 R3 R7 write address", 32'(wrAddr[k]), 32'(14'(a + 14'(k))));
          chk("R3 R4 R5 write data", 32'(wrData[k]), 32'(8'(w + 8'(k))));
        end
        chk("R2 no read on write", 32'(rdCount), 32'd0);
      end else begin
        for (int k = 0; k < nb; k++)
          chk("R3 R4 R6 R7 read byte", 32'(rxBytes[k]), 32'(rdPattern(14'(a + 14'(k)))));
        chk("R2 no write on read", 32'(wrCount), 32'd0);
        if (!e[22]) chk("R6 single fetch", 32'(rdCount), 32'd1);
      end
      chk("R10 oe after frame", 32'(misoOe), 32'd0);
      chk("R10 miso after frame", 32'(miso), 32'd0);
    end

    // R8: extra byte after a single write is ignored
    wrCount = 0;
    spiXfer(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 14'h0456, 8'h81, 2, -1);
    chk("R8 single write count", 32'(wrCount), 32'd1);
    chk("R8 single write data", 32'(wrData[0]), 32'h81);

    // R8: extra byte after a single read fetches nothing more
    rdCount = 0; wrCount = 0;
    spiXfer(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 14'h1234, 8'h00, 2, -1);
    chk("R8 single read fetch count", 32'(rdCount), 32'd1);
    chk("R8 single read byte", 32'(rxBytes[0]), 32'(rdPattern(14'h1234)));

    // R9: abort after five data bits, then a clean frame
    wrCount = 0;
    spiXfer(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0033, 8'h77, 1, 21);
    chk("R9 aborted write suppressed", 32'(wrCount), 32'd0);
    spiXfer(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0034, 8'h99, 1, -1);
    chk("R9 next frame count", 32'(wrCount), 32'd1);
    chk("R9 next frame address", 32'(wrAddr[0]), 32'h0034);
    chk("R9 next frame data", 32'(wrData[0]), 32'h99);

    // R10: output enable follows chip select
    cpolR = 1'b0; cphaR = 1'b0; sclk = 1'b0;
    csN = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 oe with select", 32'(misoOe), 32'd1);
    chk("R10 miso idle in command", 32'(miso), 32'd0);
    csN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 oe released", 32'(misoOe), 32'd0);
    chk("R1 idle write strobe", 32'(regWrEn), 32'd0);

    finishRun();
  end

endmodule